// File: doc/BRIEF.md
# Pin Event GPIO Controller

This block is a general-purpose I/O controller for up to 32 pins. Software reaches it through a small 32-bit register bus. Through that bus it can:

- read the sampled pin levels,
- gate which pins are sampled,
- set the output levels, with a per-bit inversion mask,
- choose which pins are driven.

Every pin passes through a synchronizer before any detection. Four trigger classes watch the synchronized level:

- a rising transition,
- a falling transition,
- a high level,
- a low level.

Each class keeps its own enable word and its own sticky pending word. Software clears a pending bit by writing a one to it. Each pin drives its own interrupt line, so a downstream interrupt controller can map pins one-to-one.

The bus side is a two-state machine. In state BUS_IDLE, a request takes the ACCEPT transition: a write updates the registers on that edge, and a read captures its data. The machine then sits in BUS_RESP for exactly one cycle, with the acknowledge high and the data valid. It takes the RETURN transition back to BUS_IDLE unconditionally. A request seen during BUS_RESP is not accepted until the machine is back in BUS_IDLE.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After reset, every writable register reads zero, including all four enable words and all four pending words. The irq_o and pad_oe outputs are zero.
- R2: A request in BUS_IDLE is accepted on that clock edge, and bus_ack is high for exactly the following cycle. With the acknowledge, bus_rdata holds the register value as it was when the request was accepted. For a write, bus_rdata is zero. A request held high is accepted on every second cycle.
- R3: Offset 0x00 reads the synchronized pin level ANDed with the input-enable word. The input-enable word is at offset 0x04.
- R4: pad_o equals the output-value word (0x0C) XOR the inversion word (0x40). pad_oe equals the output-enable word (0x08), and it changes only on a write to 0x08.
- R5: The rise pending word (0x1C) sets bit n when synchronized pin n goes from 0 to 1 while input-enable bit n is 1.
- R6: The fall pending word (0x24) sets bit n when synchronized pin n goes from 1 to 0 while input-enable bit n is 1.
- R7: The high pending word (0x2C) sets bit n on every cycle that synchronized pin n is 1 with input-enable bit n set. The low pending word (0x34) does the same when the pin is 0.
- R8: Pending bits are sticky. Writing 1 to a bit of a pending word clears it, and writing 0 leaves it unchanged.
- R9: When a set event and a write-one clear hit the same pending bit in the same cycle, the bit ends set.
- R10: No pending bit sets while the pin's input-enable bit is 0.
- R11: irq_o[n] is 1 when, for any class, both enable bit n and pending bit n are set. The enable words are rise 0x18, fall 0x20, high 0x28 and low 0x30.
- R12: Writes to offset 0x00 have no effect. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| pin_i | input | N_PINS | Asynchronous pin levels |
| pad_o | output | N_PINS | Output levels after inversion |
| pad_oe | output | N_PINS | Per-pin drive enable |
| irq_o | output | N_PINS | Per-pin interrupt lines |

## Verification
The assertions watch several properties on every cycle:

- the one-cycle acknowledge after each accepted request;
- pending bits never dropping without a clear;
- a set event overriding a clear in the same cycle;
- no pending bit rising while its input-enable bit is low;
- the drive enables holding unless their register is written.

Only the bench's scenarios can show that each pin pattern maps onto the right class and bit position. The same goes for level-versus-edge behaviour when input enable is switched on under a pin that is already high, the read-data values, and the composition of the per-pin interrupt lines.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_PIN_LVL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_IN_EN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_OUT_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_OUT_VAL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_INVERT  = 8'h40;

    localparam int N_CLASS = 4;

    // class order: rise, fall, high, low (sets the register layout)
    typedef enum logic [1:0] {
        CLS_RISE = 2'd0,
        CLS_FALL = 2'd1,
        CLS_HIGH = 2'd2,
        CLS_LOW  = 2'd3
    } trig_class_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // enable word of class k sits at 0x18 + 8k, its pending word 4 bytes above
    function automatic logic [ADDR_W-1:0] enable_off(input int k);
        return ADDR_W'(8'h18 + 8 * k);
    endfunction

    function automatic logic [ADDR_W-1:0] pending_off(input int k);
        return ADDR_W'(8'h1C + 8 * k);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] pend_q;

    // set overrides a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_chk
            assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[b] && !clr_i[b]) |=> pend_q[b]);
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (set_i[b] && clr_i[b]) |=> pend_q[b]);
            assert_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (!en_i[b] && !pend_q[b]) |=> !pend_q[b]);
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_event_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_i,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [BUS_W-1:0]               wdata_i,
    output logic [BUS_W-1:0]               rdata_o,
    output logic                           ack_o,
    input  logic [WIDTH-1:0]               pin_sync_i,
    input  logic [N_CLASS-1:0][WIDTH-1:0]  pend_i,
    output logic [WIDTH-1:0]               in_en_o,
    output logic [WIDTH-1:0]               out_en_o,
    output logic [WIDTH-1:0]               out_val_o,
    output logic [WIDTH-1:0]               invert_o,
    output logic [N_CLASS-1:0][WIDTH-1:0]  ie_o,
    output logic [N_CLASS-1:0][WIDTH-1:0]  clr_o
);
    bus_state_e state_q, state_d;
    logic       accept;
    logic       wr_acc;
    logic [WIDTH-1:0] wbits;
    logic [BUS_W-1:0] rd_mux;

    assign accept = req_i && (state_q == BUS_IDLE);
    assign wr_acc = accept && we_i;
    assign wbits  = wdata_i[WIDTH-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT (idle -> resp), RETURN (resp -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        unique case (addr_i)
            OFF_PIN_LVL: rd_mux = BUS_W'(pin_sync_i & in_en_o);
            OFF_IN_EN:   rd_mux = BUS_W'(in_en_o);
            OFF_OUT_EN:  rd_mux = BUS_W'(out_en_o);
            OFF_OUT_VAL: rd_mux = BUS_W'(out_val_o);
            OFF_INVERT:  rd_mux = BUS_W'(invert_o);
            default:     rd_mux = '0;
        endcase
        for (int k = 0; k < N_CLASS; k++) begin
            if (addr_i == enable_off(k))  rd_mux = BUS_W'(ie_o[k]);
            if (addr_i == pending_off(k)) rd_mux = BUS_W'(pend_i[k]);
        end
    end

    // outputs of the bus machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o <= accept;
            if (accept) rdata_o <= we_i ? '0 : rd_mux;
        end
    end

    // configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_en_o   <= '0;
            out_en_o  <= '0;
            out_val_o <= '0;
            invert_o  <= '0;
            ie_o      <= '0;
        end else if (wr_acc) begin
            if (addr_i == OFF_IN_EN)   in_en_o   <= wbits;
            if (addr_i == OFF_OUT_EN)  out_en_o  <= wbits;
            if (addr_i == OFF_OUT_VAL) out_val_o <= wbits;
            if (addr_i == OFF_INVERT)  invert_o  <= wbits;
            for (int k = 0; k < N_CLASS; k++)
                if (addr_i == enable_off(k)) ie_o[k] <= wbits;
        end
    end

    // write-one-to-clear strobes toward the pending words
    always_comb begin
        for (int k = 0; k < N_CLASS; k++)
            clr_o[k] = (wr_acc && addr_i == pending_off(k)) ? wbits : '0;
    end

    assert_ack_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ack_o);
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && addr_i == OFF_OUT_EN) |=> $stable(out_en_o));
endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl
    import gpio_event_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] pad_o,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] irq_o
);
    logic [N_PINS-1:0] lvl, prev_q;
    logic [N_PINS-1:0] in_en, out_en, out_val, invert;
    logic [N_CLASS-1:0][N_PINS-1:0] ie, pend, setv, clr;

    gpio_pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign setv[CLS_RISE] = in_en &  lvl & ~prev_q;
    assign setv[CLS_FALL] = in_en & ~lvl &  prev_q;
    assign setv[CLS_HIGH] = in_en &  lvl;
    assign setv[CLS_LOW]  = in_en & ~lvl;

    genvar k;
    generate
        for (k = 0; k < N_CLASS; k++) begin : g_class
            gpio_pend #(.WIDTH(N_PINS)) u_pend (
                .clk(clk), .rst_n(rst_n), .en_i(in_en),
                .set_i(setv[k]), .clr_i(clr[k]), .pend_o(pend[k])
            );
        end
    endgenerate

    gpio_regs #(.WIDTH(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_i(bus_req), .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .rdata_o(bus_rdata), .ack_o(bus_ack),
        .pin_sync_i(lvl), .pend_i(pend),
        .in_en_o(in_en), .out_en_o(out_en), .out_val_o(out_val), .invert_o(invert),
        .ie_o(ie), .clr_o(clr)
    );

    always_comb begin
        irq_o = '0;
        for (int c = 0; c < N_CLASS; c++) irq_o = irq_o | (ie[c] & pend[c]);
    end

    assign pad_o  = out_val ^ invert;
    assign pad_oe = out_en;
endmodule

// File: tb/sim_gpio_event_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_event_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [31:0] pin_i = '0;
    logic [31:0] pad_o, pad_oe, irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_event_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .pin_i(pin_i), .pad_o(pad_o), .pad_oe(pad_oe),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every acknowledge consumes one expected item
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected ack", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        exp_q.push_back(32'h0); tag_q.push_back("R2 write rdata");
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq_o, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        rd(8'h04, 32'h0, "R1 in_en");
        rd(8'h18, 32'h0, "R1 rise_ie");
        rd(8'h30, 32'h0, "R1 low_ie");
        rd(8'h34, 32'h0, "R1 low_pend");

        // R2 held request: ack pattern 1,0,1
        exp_q.push_back(32'h0); tag_q.push_back("R2 held rd1");
        exp_q.push_back(32'h0); tag_q.push_back("R2 held rd2");
        @(negedge clk); bus_req = 1'b1; bus_addr = 8'h08;
        @(negedge clk); chk("R2 ack1", {31'b0, bus_ack}, 32'd1);
        @(negedge clk); chk("R2 ack gap", {31'b0, bus_ack}, 32'd0);
        @(negedge clk); chk("R2 ack2", {31'b0, bus_ack}, 32'd1);
        bus_req = 1'b0;
        @(negedge clk);

        // R4 output path
        wr(8'h0C, 32'hA5A5_0F0F);
        wr(8'h40, 32'hFFFF_0000);
        wr(8'h08, 32'h0000_FFFF);
        chk("R4 pad_o", pad_o, 32'h5A5A_0F0F);
        chk("R4 pad_oe", pad_oe, 32'h0000_FFFF);
        rd(8'h40, 32'hFFFF_0000, "R4 invert readback");

        // R10 / R3: pins change while input enable is zero
        pin_i = 32'h8000_00F3;
        settle();
        rd(8'h00, 32'h0, "R3 gated level");
        rd(8'h1C, 32'h0, "R10 rise pend");
        rd(8'h2C, 32'h0, "R10 high pend");

        // enable low byte: levels set, no edge
        wr(8'h04, 32'h0000_00FF);
        settle();
        rd(8'h00, 32'h0000_00F3, "R3 level");
        rd(8'h1C, 32'h0, "R5 no edge at enable");
        rd(8'h2C, 32'h0000_00F3, "R7 high pend");
        rd(8'h34, 32'h0000_000C, "R7 low pend");

        // R9: clear while level persists
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, 32'h0000_00F3, "R9 set wins");

        // R5 / R6 edges
        wr(8'h34, 32'hFFFF_FFFF);
        pin_i = 32'h8000_003C;
        settle();
        rd(8'h1C, 32'h0000_000C, "R5 rise pend");
        rd(8'h24, 32'h0000_00C3, "R6 fall pend");

        // R8 write-zero and write-one
        wr(8'h1C, 32'h0);
        rd(8'h1C, 32'h0000_000C, "R8 zero keeps");
        wr(8'h1C, 32'h0000_0004);
        rd(8'h1C, 32'h0000_0008, "R8 one clears");

        // R11 per-pin interrupts
        wr(8'h18, 32'h0000_0008);
        chk("R11 rise irq", irq_o, 32'h0000_0008);
        wr(8'h20, 32'h0000_0040);
        chk("R11 rise+fall irq", irq_o, 32'h0000_0048);
        wr(8'h1C, 32'h0000_0008);
        chk("R11 after clear", irq_o, 32'h0000_0040);

        // R12 read-only and unmapped
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_003C, "R12 level write ignored");
        rd(8'h10, 32'h0, "R12 unmapped");

        repeat (3) @(negedge clk);
        chk("R2 queue drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule